// File: doc/BRIEF.md
# Storage Card Host Register Interface

This block is the software-visible register front end of a simple storage-card host controller. A processor reaches it over a 32-bit bus with word-aligned addresses and a single-cycle read or write strobe. Through it software programs the memory buffer address for data transfers, the command argument, the block geometry and the interrupt mask. It launches a command by writing the command word, collects the response words afterwards, and services one level-sensitive interrupt line.

The command engine that talks to the card sits outside this block. It receives a one-cycle start strobe together with the command word, the held argument, the buffer address and the block geometry. It reports back through a completion strobe carrying completion flags, a card-change event input and a response-word load port. Pending interrupt causes are kept here. A status read is filtered through the enable mask. Writing the mask also discards every pending cause. Block length and block count are programmed as value minus one.

Register word offsets (byte address): 0x00 interrupt status, 0x04 interrupt enable, 0x08 buffer address, 0x0C command, 0x10 argument, 0x14/0x18/0x1C/0x20 response words 0 to 3 (word 0 holds bits 31:0, word 3 holds bits 127:96), 0x24 block length, 0x28 block count, 0x2C card state. Interrupt cause bits are: bit 0 command finished, bit 1 data finished, bit 2 card state changed.

Top module: `chr_host_regs`

## Requirements
- R1: After reset every register reads zero except the card state word, `irq` is 0, `cmd_start` is 0, and the `buf_addr`, `cmd_arg`, `cmd_code`, `blk_len` and `blk_cnt` outputs are 0.
- R2: A read of offset 0x00 returns the pending cause bits ANDed with the enable mask in bits 2:0, and zero above them. Causes outside the mask stay pending but do not show in the read.
- R3: A write to offset 0x00 clears each pending cause whose bit is 1 in the written data (bits 2:0). Bits written as 0 leave their causes unchanged.
- R4: A write to offset 0x04 loads the enable mask from data bits 2:0 and clears all pending causes in the same cycle. A read of 0x04 returns the mask.
- R5: A write to 0x24 or 0x28 stores the written value plus one, modulo 2^32. The stored value is read back at the same offset and driven on `blk_len` or `blk_cnt`.
- R6: A read of 0x2C returns bit 0 = 1 (card inserted) and bit 1 = `card_ro`, with all other bits zero.
- R7: A write to 0x0C stores the value on `cmd_code` and raises `cmd_start` for exactly the next cycle. During that cycle `cmd_arg` shows the argument written earlier to 0x10.
- R8: A cycle with `eng_done` high ORs `eng_flags` into the pending causes. A cycle with `card_evt` high sets cause bit 2. Events in the same cycle as a status or enable write are kept.
- R9: `irq` is registered. From the clock edge that updates the causes or the mask, it equals the OR of (pending causes AND enable mask).
- R10: A cycle with `rsp_we` high loads `rsp_word` into response word `rsp_idx`. Reads of 0x14 + 4*i return word i, and bus writes to those offsets have no effect.
- R11: A read of any offset above 0x2C returns zero. Writes to 0x2C or to any unmapped offset change no register.
- R12: Writes to 0x08 and 0x10 are stored, read back at the same offset, and driven on `buf_addr` and `cmd_arg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_addr | input | ADDR_W | Byte address, bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |
| cmd_start | output | 1 | One-cycle command launch strobe |
| cmd_code | output | 32 | Last command word written |
| cmd_arg | output | 32 | Held command argument |
| buf_addr | output | 32 | Transfer buffer address |
| blk_len | output | 32 | Block length (stored value) |
| blk_cnt | output | 32 | Block count (stored value) |
| eng_done | input | 1 | Command engine completion strobe |
| eng_flags | input | 3 | Cause bits to post on completion |
| card_evt | input | 1 | Card insertion or removal event strobe |
| card_ro | input | 1 | Card write-protect level |
| rsp_we | input | 1 | Response word load strobe |
| rsp_idx | input | 2 | Response word index |
| rsp_word | input | 32 | Response word value |

## Verification
The properties assume the bus raises at most one of `bus_wr` and `bus_rd` in a cycle, and that the address is stable while the strobe is high. The status-clearing and mask-wiping properties are conditioned on no engine or card event arriving in the same cycle, because such an event is kept by design. The bench drives every strobe for exactly one cycle from the falling edge. It applies completion and card events in cycles apart from bus writes, except where same-cycle ordering is the point of the test, and it never issues a read and a write together.

// File: rtl/chr_pkg.sv
package chr_pkg;
  localparam int DW    = 32;
  localparam int NF    = 3;   // interrupt cause bits
  localparam int NRSP  = 4;   // response words

  // word indices of the register map (byte offset / 4)
  localparam int W_ISTAT = 0;
  localparam int W_IEN   = 1;
  localparam int W_BUF   = 2;
  localparam int W_CMD   = 3;
  localparam int W_ARG   = 4;
  localparam int W_RSP0  = 5;
  localparam int W_BLEN  = 9;
  localparam int W_BCNT  = 10;
  localparam int W_CARD  = 11;

  // stored geometry value from the programmed minus-one value
  function automatic logic [DW-1:0] f_plus_one(input logic [DW-1:0] v);
    return v + DW'(1);
  endfunction

  // cause bits visible to software and to the interrupt line
  function automatic logic [NF-1:0] f_visible(input logic [NF-1:0] st,
                                              input logic [NF-1:0] en);
    return st & en;
  endfunction

  // next pending causes: a mask write wipes, else write-one-to-clear, then new events
  function automatic logic [NF-1:0] f_next_status(input logic [NF-1:0] st,
                                                  input logic          wipe,
                                                  input logic          clr,
                                                  input logic [NF-1:0] clr_bits,
                                                  input logic [NF-1:0] set_bits);
    logic [NF-1:0] r;
    if (wipe)      r = '0;
    else if (clr)  r = st & ~clr_bits;
    else           r = st;
    return r | set_bits;
  endfunction
endpackage

// File: rtl/chr_irq_unit.sv
module chr_irq_unit
  import chr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          clr_wr,
  input  logic [NF-1:0] wr_bits,
  input  logic [NF-1:0] set_bits,
  output logic [NF-1:0] st_q,
  output logic [NF-1:0] en_q,
  output logic          irq_q
);
  logic [NF-1:0] st_d;
  logic [NF-1:0] en_d;

  always_comb begin
    en_d = en_wr ? wr_bits : en_q;
    st_d = f_next_status(st_q, en_wr, clr_wr, wr_bits, set_bits);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      en_q  <= en_d;
      irq_q <= |f_visible(st_d, en_d);
    end
  end
endmodule

// File: rtl/chr_cfg_regs.sv
module chr_cfg_regs
  import chr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_buf,
  input  logic                    wr_arg,
  input  logic                    wr_cmd,
  input  logic                    wr_len,
  input  logic                    wr_cnt,
  input  logic [DW-1:0]           wdata,
  input  logic                    rsp_we,
  input  logic [$clog2(NRSP)-1:0] rsp_idx,
  input  logic [DW-1:0]           rsp_word,
  output logic [DW-1:0]           buf_q,
  output logic [DW-1:0]           arg_q,
  output logic [DW-1:0]           cmd_q,
  output logic [DW-1:0]           len_q,
  output logic [DW-1:0]           cnt_q,
  output logic [DW-1:0]           rsp_q [NRSP],
  output logic                    start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= '0;
      arg_q   <= '0;
      cmd_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= wr_cmd;
      if (wr_buf) buf_q <= wdata;
      if (wr_arg) arg_q <= wdata;
      if (wr_cmd) cmd_q <= wdata;
      if (wr_len) len_q <= f_plus_one(wdata);
      if (wr_cnt) cnt_q <= f_plus_one(wdata);
    end
  end

  for (genvar gi = 0; gi < NRSP; gi++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rst_n)                                          rsp_q[gi] <= '0;
      else if (rsp_we && rsp_idx == ($clog2(NRSP))'(gi))   rsp_q[gi] <= rsp_word;
    end
  end
endmodule

// File: rtl/chr_host_regs.sv
module chr_host_regs
  import chr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              cmd_start,
  output logic [31:0]       cmd_code,
  output logic [31:0]       cmd_arg,
  output logic [31:0]       buf_addr,
  output logic [31:0]       blk_len,
  output logic [31:0]       blk_cnt,
  input  logic              eng_done,
  input  logic [2:0]        eng_flags,
  input  logic              card_evt,
  input  logic              card_ro,
  input  logic              rsp_we,
  input  logic [1:0]        rsp_idx,
  input  logic [31:0]       rsp_word
);
  localparam int WIX_W = ADDR_W - 2;

  logic [WIX_W-1:0] widx;
  logic [NF-1:0]    st_q, en_q, set_bits;
  logic [DW-1:0]    rsp_q [NRSP];
  logic [DW-1:0]    rd_mux;
  // named write decodes, visible to the checker
  logic             wr_istat, wr_ien, wr_buf, wr_arg, wr_cmd, wr_len, wr_cnt;

  assign widx     = bus_addr[ADDR_W-1:2];
  assign wr_istat = bus_wr && widx == WIX_W'(W_ISTAT);
  assign wr_ien   = bus_wr && widx == WIX_W'(W_IEN);
  assign wr_buf   = bus_wr && widx == WIX_W'(W_BUF);
  assign wr_cmd   = bus_wr && widx == WIX_W'(W_CMD);
  assign wr_arg   = bus_wr && widx == WIX_W'(W_ARG);
  assign wr_len   = bus_wr && widx == WIX_W'(W_BLEN);
  assign wr_cnt   = bus_wr && widx == WIX_W'(W_BCNT);
  assign set_bits = (eng_done ? eng_flags : '0) | {card_evt, {(NF-1){1'b0}}};

  chr_irq_unit u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (wr_ien),
    .clr_wr   (wr_istat),
    .wr_bits  (bus_wdata[NF-1:0]),
    .set_bits (set_bits),
    .st_q     (st_q),
    .en_q     (en_q),
    .irq_q    (irq)
  );

  chr_cfg_regs u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_buf   (wr_buf),
    .wr_arg   (wr_arg),
    .wr_cmd   (wr_cmd),
    .wr_len   (wr_len),
    .wr_cnt   (wr_cnt),
    .wdata    (bus_wdata),
    .rsp_we   (rsp_we),
    .rsp_idx  (rsp_idx),
    .rsp_word (rsp_word),
    .buf_q    (buf_addr),
    .arg_q    (cmd_arg),
    .cmd_q    (cmd_code),
    .len_q    (blk_len),
    .cnt_q    (blk_cnt),
    .rsp_q    (rsp_q),
    .start_q  (cmd_start)
  );

  always_comb begin
    rd_mux = '0;
    if      (widx == WIX_W'(W_ISTAT)) rd_mux = DW'(f_visible(st_q, en_q));
    else if (widx == WIX_W'(W_IEN))   rd_mux = DW'(en_q);
    else if (widx == WIX_W'(W_BUF))   rd_mux = buf_addr;
    else if (widx == WIX_W'(W_CMD))   rd_mux = cmd_code;
    else if (widx == WIX_W'(W_ARG))   rd_mux = cmd_arg;
    else if (widx == WIX_W'(W_BLEN))  rd_mux = blk_len;
    else if (widx == WIX_W'(W_BCNT))  rd_mux = blk_cnt;
    else if (widx == WIX_W'(W_CARD))  rd_mux = {{(DW-2){1'b0}}, card_ro, 1'b1};
    for (int i = 0; i < NRSP; i++)
      if (widx == WIX_W'(W_RSP0 + i)) rd_mux = rsp_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/chr_regs_chk.sv
module chr_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_istat,
  input logic        wr_ien,
  input logic        wr_cmd,
  input logic        wr_len,
  input logic        wr_cnt,
  input logic [31:0] bus_wdata,
  input logic        irq,
  input logic        cmd_start,
  input logic [31:0] cmd_code,
  input logic [31:0] blk_len,
  input logic [31:0] blk_cnt,
  input logic        eng_done,
  input logic [2:0]  eng_flags,
  input logic        card_evt,
  input logic [2:0]  st_q,
  input logic [2:0]  en_q
);
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(st_q & en_q));  // R9

  AST_CMD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> cmd_start && cmd_code == $past(bus_wdata));  // R7

  AST_NO_SPURIOUS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> !cmd_start);  // R7

  AST_LEN_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_len |=> blk_len == $past(bus_wdata) + 32'd1);  // R5

  AST_CNT_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> blk_cnt == $past(bus_wdata) + 32'd1);  // R5

  AST_MASK_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ien && !eng_done && !card_evt) |=> st_q == 3'b000);  // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && !eng_done && !card_evt) |=> (st_q & $past(bus_wdata[2:0])) == 3'b000);  // R3

  AST_DONE_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> (st_q & $past(eng_flags)) == $past(eng_flags));  // R8
endmodule

bind chr_host_regs chr_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_istat  (wr_istat),
  .wr_ien    (wr_ien),
  .wr_cmd    (wr_cmd),
  .wr_len    (wr_len),
  .wr_cnt    (wr_cnt),
  .bus_wdata (bus_wdata),
  .irq       (irq),
  .cmd_start (cmd_start),
  .cmd_code  (cmd_code),
  .blk_len   (blk_len),
  .blk_cnt   (blk_cnt),
  .eng_done  (eng_done),
  .eng_flags (eng_flags),
  .card_evt  (card_evt),
  .st_q      (st_q),
  .en_q      (en_q)
);

// File: tb/chr_host_regs_tb.sv
module chr_host_regs_tb;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq, cmd_start;
  logic [31:0]       cmd_code, cmd_arg, buf_addr, blk_len, blk_cnt;
  logic              eng_done = 1'b0;
  logic [2:0]        eng_flags = '0;
  logic              card_evt = 1'b0, card_ro = 1'b0;
  logic              rsp_we = 1'b0;
  logic [1:0]        rsp_idx = '0;
  logic [31:0]       rsp_word = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;  // 250 MHz

  chr_host_regs #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic bwrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic engine(input logic [2:0] f);
    eng_done = 1'b1; eng_flags = f;
    @(negedge clk);
    eng_done = 1'b0; eng_flags = '0;
  endtask

  task automatic card_event();
    card_evt = 1'b1;
    @(negedge clk);
    card_evt = 1'b0;
  endtask

  task automatic t_reset();
    eq("R1 irq", {31'b0, irq}, 0);
    eq("R1 cmd_start", {31'b0, cmd_start}, 0);
    eq("R1 blk_len", blk_len, 0);
    eq("R1 blk_cnt", blk_cnt, 0);
    eq("R1 buf_addr", buf_addr, 0);
    eq("R1 cmd_arg", cmd_arg, 0);
    eq("R1 cmd_code", cmd_code, 0);
    for (int i = 0; i < 11; i++) begin
      bread(ADDR_W'(i * 4), rv);
      eq($sformatf("R1 reg 0x%0h", i * 4), rv, 0);
    end
    bread(12'h02C, rv);
    eq("R6 card state writable", rv, 32'h1);
  endtask

  task automatic t_card();
    card_ro = 1'b1;
    bread(12'h02C, rv);
    eq("R6 card read-only", rv, 32'h3);
    card_ro = 1'b0;
    bread(12'h02C, rv);
    eq("R6 card writable", rv, 32'h1);
  endtask

  task automatic t_cfg();
    bwrite(12'h008, 32'h8000_1000);
    bwrite(12'h010, 32'h0000_4400);
    bread(12'h008, rv);  eq("R12 buf read", rv, 32'h8000_1000);
    bread(12'h010, rv);  eq("R12 arg read", rv, 32'h0000_4400);
    eq("R12 buf_addr out", buf_addr, 32'h8000_1000);
    eq("R12 cmd_arg out", cmd_arg, 32'h0000_4400);
    bwrite(12'h024, 32'h0000_01FF);
    eq("R5 blk_len out", blk_len, 32'h200);
    bread(12'h024, rv);  eq("R5 blk_len read", rv, 32'h200);
    bwrite(12'h028, 32'h0);
    eq("R5 blk_cnt min", blk_cnt, 32'h1);
    bwrite(12'h028, 32'hFFFF_FFFF);
    bread(12'h028, rv);  eq("R5 blk_cnt wrap", rv, 32'h0);
    bwrite(12'h028, 32'h7);
    eq("R5 blk_cnt eight", blk_cnt, 32'h8);
  endtask

  task automatic t_cmd();
    bwrite(12'h010, 32'h0000_1234);
    eq("R7 idle before", {31'b0, cmd_start}, 0);
    bwrite(12'h00C, 32'h0000_0051);
    eq("R7 start pulse", {31'b0, cmd_start}, 1);
    eq("R7 code", cmd_code, 32'h51);
    eq("R7 arg held", cmd_arg, 32'h1234);
    @(negedge clk);
    eq("R7 pulse one cycle", {31'b0, cmd_start}, 0);
    bwrite(12'h00C, 32'h0000_0011);
    bwrite(12'h00C, 32'h0000_0012);
    eq("R7 back-to-back start", {31'b0, cmd_start}, 1);
    eq("R7 back-to-back code", cmd_code, 32'h12);
    bread(12'h00C, rv);  eq("R7 code read", rv, 32'h12);
  endtask

  task automatic t_irq();
    bwrite(12'h004, 32'h0);
    engine(3'b011);
    eq("R9 masked no irq", {31'b0, irq}, 0);
    bread(12'h000, rv);  eq("R2 masked read", rv, 0);
    bwrite(12'h004, 32'h3);
    eq("R4 wipe no irq", {31'b0, irq}, 0);
    bread(12'h000, rv);  eq("R4 wiped status", rv, 0);
    bread(12'h004, rv);  eq("R4 mask read", rv, 32'h3);
    engine(3'b001);
    eq("R9 irq raised", {31'b0, irq}, 1);
    bread(12'h000, rv);  eq("R8 cmd done bit", rv, 32'h1);
    card_event();
    bread(12'h000, rv);  eq("R2 bit2 hidden", rv, 32'h1);
    bwrite(12'h000, 32'h1);
    eq("R3 irq drops", {31'b0, irq}, 0);
    bread(12'h000, rv);  eq("R3 cleared", rv, 0);
    bwrite(12'h004, 32'h7);
    bread(12'h000, rv);  eq("R4 bit2 wiped", rv, 0);
    card_event();
    eq("R9 card irq", {31'b0, irq}, 1);
    bwrite(12'h000, 32'h2);
    bread(12'h000, rv);  eq("R3 zero bits keep", rv, 32'h4);
    // event in the same cycle as a clear is kept
    eng_done = 1'b1; eng_flags = 3'b010;
    bwrite(12'h000, 32'h7);
    eng_done = 1'b0; eng_flags = '0;
    bread(12'h000, rv);  eq("R8 same-cycle event kept", rv, 32'h2);
    eq("R9 irq from kept event", {31'b0, irq}, 1);
    bwrite(12'h000, 32'h7);
    eq("R9 irq low at end", {31'b0, irq}, 0);
  endtask

  task automatic t_rsp();
    for (int i = 0; i < 4; i++) begin
      rsp_we = 1'b1; rsp_idx = 2'(i); rsp_word = 32'hA5C0_0000 + 32'(i * 17);
      @(negedge clk);
    end
    rsp_we = 1'b0;
    for (int i = 0; i < 4; i++) begin
      bread(ADDR_W'(12'h014 + i * 4), rv);
      eq($sformatf("R10 rsp%0d", i), rv, 32'hA5C0_0000 + 32'(i * 17));
    end
    bwrite(12'h014, 32'hDEAD_BEEF);
    bwrite(12'h020, 32'hDEAD_BEEF);
    bread(12'h014, rv);  eq("R10 bus write ignored w0", rv, 32'hA5C0_0000);
    bread(12'h020, rv);  eq("R10 bus write ignored w3", rv, 32'hA5C0_0033);
  endtask

  task automatic t_unmapped();
    bread(12'h030, rv);  eq("R11 read 0x30", rv, 0);
    bread(12'hFFC, rv);  eq("R11 read top", rv, 0);
    bwrite(12'h02C, 32'hFFFF_FFFF);
    bwrite(12'h030, 32'hFFFF_FFFF);
    bwrite(12'h800, 32'hFFFF_FFFF);
    bread(12'h02C, rv);  eq("R11 card state unchanged", rv, 32'h1);
    bread(12'h030, rv);  eq("R11 unmapped still zero", rv, 0);
    eq("R11 blk_cnt unchanged", blk_cnt, 32'h8);
    eq("R11 buf_addr unchanged", buf_addr, 32'h8000_1000);
    eq("R11 no start", {31'b0, cmd_start}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_card();
    t_cfg();
    t_cmd();
    t_irq();
    t_rsp();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule